// File: doc/BRIEF.md
# Multi-Register Stack Transfer Sequencer

This block is the control sequencer that moves a group of general registers to or from a memory stack. It takes one instruction word. The word names a stack-pointer register and either a single data register or a 16-bit selection mask. The sequencer then walks the selected registers. For each one it makes a single 32-bit memory access, either a store for a push or a load for a pop, and it moves the stack pointer by 4. When the selection is used up, it writes the final stack pointer back and raises `done` for one cycle.

The register file and the memory sit outside the block. The sequencer drives one asynchronous read port and one write port of the register file. Its memory request is held steady until the memory acknowledges it.

Instructions arrive on a valid/ready channel. `instr_ready` is high only while the sequencer is idle. A word is taken in the cycle where `instr_valid` and `instr_ready` are both high. While `instr_ready` is low, the source must hold `instr_valid` and `instr` steady. The memory port applies back-pressure in the same way: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until `mem_ack` is high.

Top module: `pp_seq`

## Requirements
- R1: `instr_ready` is high only when idle. A word is consumed on `instr_valid && instr_ready`. `instr_ready` is low from the cycle after acceptance until the cycle after `done`.
- R2: Opcode is `instr[31:24]`: 0x60 single push, 0x61 single pop, 0x62 multi push, 0x63 multi pop. The stack register is `instr[19:16]`, the mask is `instr[15:0]` (bit k selects register k), and the single-op register is `instr[23:20]`.
- R3: A push handles selected registers from index 0 upward. For each one it stores the register at SP-4, and SP-4 becomes the new SP.
- R4: A pop handles selected registers from index 15 downward. For each one it loads the register from SP and then adds 4 to SP. Popping the mask that was pushed restores every register.
- R5: In the `done` cycle the final SP is written into the stack register. This leaves it 4 per selected register lower after a push and higher after a pop.
- R6: With memory that acknowledges in the request cycle, the count from the accept cycle to the `done` cycle, inclusive, is 3+2N for multi ops. It is 4 for a single push and 3 for a single pop.
- R7: A multi op with an empty mask finishes in 3 cycles. It makes no memory request and no register write.
- R8: If the stack register is itself selected, a push stores its value from before the instruction. In a pop, the final SP write overrides the loaded value.
- R9: Each memory wait cycle adds exactly one cycle to the instruction.
- R10: Any other opcode is consumed and `done` follows in the next cycle. It causes no memory request and no register write.
- R11: After reset `instr_ready` is 1, and `mem_req`, `rf_we` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Sequencer idle, word accepted this cycle if valid |
| instr | input | 32 | Instruction word |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (same cycle) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 store, 0 load |
| mem_addr | output | 32 | Byte address of the longword |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Load data, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the sequencer with its default 16 registers of 32 bits. That lets it use the full 0xFFFF mask and a stack register that sits inside the mask. The bench memory model has a wait-state count set by the bench. It runs at zero to check the exact cycle counts, and at two to check that a held request stretches each access by exactly the wait time.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int INSTR_W = 32;

  localparam logic [7:0] OPC_PUSH1 = 8'h60;
  localparam logic [7:0] OPC_POP1  = 8'h61;
  localparam logic [7:0] OPC_PUSHM = 8'h62;
  localparam logic [7:0] OPC_POPM  = 8'h63;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_GET,
    ST_PUT,
    ST_FUSED,
    ST_FIN
  } seq_state_t;
endpackage

// File: rtl/pp_decode.sv
module pp_decode
  import pp_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int REG_AW = $clog2(NREG)
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               ok,
  output logic               pop,
  output logic               multi,
  output logic [REG_AW-1:0]  sp_sel,
  output logic [NREG-1:0]    sel_mask
);
  logic [7:0]        opc;
  logic [REG_AW-1:0] one_reg;

  assign opc     = instr[31:24];
  assign one_reg = instr[20 +: REG_AW];
  assign sp_sel  = instr[16 +: REG_AW];

  always_comb begin
    ok       = 1'b1;
    pop      = 1'b0;
    multi    = 1'b0;
    sel_mask = '0;
    unique case (opc)
      OPC_PUSH1: sel_mask[one_reg] = 1'b1;
      OPC_POP1: begin
        pop = 1'b1;
        sel_mask[one_reg] = 1'b1;
      end
      OPC_PUSHM: begin
        multi    = 1'b1;
        sel_mask = instr[NREG-1:0];
      end
      OPC_POPM: begin
        multi    = 1'b1;
        pop      = 1'b1;
        sel_mask = instr[NREG-1:0];
      end
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/pp_pick.sv
module pp_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  input  logic          hi_first,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [N-1:0]  lo_hit;
  logic [N-1:0]  hi_hit;
  logic [IW-1:0] lo_idx;
  logic [IW-1:0] hi_idx;

  generate
    for (genvar g = 0; g < N; g++) begin : g_hit
      if (g == 0) begin : g_first
        assign lo_hit[g]     = mask[g];
        assign hi_hit[N-1-g] = mask[N-1-g];
      end else begin : g_rest
        assign lo_hit[g]     = mask[g] & ~|mask[g-1:0];
        assign hi_hit[N-1-g] = mask[N-1-g] & ~|mask[N-1:N-g];
      end
    end
  endgenerate

  always_comb begin
    lo_idx = '0;
    hi_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (lo_hit[i]) lo_idx = IW'(i);
      if (hi_hit[i]) hi_idx = IW'(i);
    end
  end

  assign found = |mask;
  assign idx   = hi_first ? hi_idx : lo_idx;
endmodule

// File: rtl/pp_sp_unit.sv
module pp_sp_unit #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] sp,
  input  logic          dec,
  output logic [AW-1:0] acc_addr,
  output logic [AW-1:0] next_sp
);
  logic [AW-1:0] sp_down;
  logic [AW-1:0] sp_up;

  assign sp_down  = sp - AW'(STEP);
  assign sp_up    = sp + AW'(STEP);
  assign acc_addr = dec ? sp_down : sp;
  assign next_sp  = dec ? sp_down : sp_up;
endmodule

// File: rtl/pp_seq.sv
module pp_seq
  import pp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  localparam int REG_AW = $clog2(NREG),
  localparam int STEP   = DATA_W / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_valid,
  output logic                instr_ready,
  input  logic [INSTR_W-1:0]  instr,
  output logic [REG_AW-1:0]   rf_raddr,
  input  logic [DATA_W-1:0]   rf_rdata,
  output logic                rf_we,
  output logic [REG_AW-1:0]   rf_waddr,
  output logic [DATA_W-1:0]   rf_wdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [DATA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                done
);
  seq_state_t        state_q, state_d;
  logic              pop_q;
  logic              moved_q;
  logic [REG_AW-1:0] sp_sel_q;
  logic [NREG-1:0]   mask_q;
  logic [DATA_W-1:0] sp_q;
  logic [DATA_W-1:0] hold_q;

  logic              dec_ok, dec_pop, dec_multi;
  logic [REG_AW-1:0] dec_sp;
  logic [NREG-1:0]   dec_mask;
  logic              pick_found;
  logic [REG_AW-1:0] pick_idx;
  logic [NREG-1:0]   mask_left;
  logic [DATA_W-1:0] acc_addr, next_sp;
  logic              fire;

  pp_decode #(.NREG(NREG), .REG_AW(REG_AW)) u_decode (
    .instr    (instr),
    .ok       (dec_ok),
    .pop      (dec_pop),
    .multi    (dec_multi),
    .sp_sel   (dec_sp),
    .sel_mask (dec_mask)
  );

  pp_pick #(.N(NREG), .IW(REG_AW)) u_pick (
    .mask     (mask_q),
    .hi_first (pop_q),
    .found    (pick_found),
    .idx      (pick_idx)
  );

  pp_sp_unit #(.AW(DATA_W), .STEP(STEP)) u_sp (
    .sp       (sp_q),
    .dec      (~pop_q),
    .acc_addr (acc_addr),
    .next_sp  (next_sp)
  );

  assign instr_ready = (state_q == ST_IDLE);
  assign fire        = instr_valid & instr_ready;

  always_comb begin
    mask_left           = mask_q;
    mask_left[pick_idx] = 1'b0;
  end

  // Port drive per state
  always_comb begin
    rf_raddr  = (state_q == ST_IDLE) ? dec_sp : pick_idx;
    rf_we     = 1'b0;
    rf_waddr  = pick_idx;
    rf_wdata  = hold_q;
    mem_req   = 1'b0;
    mem_we    = ~pop_q;
    mem_addr  = acc_addr;
    mem_wdata = hold_q;
    done      = 1'b0;
    unique case (state_q)
      ST_GET:   mem_req = pop_q;
      ST_PUT: begin
        mem_req = ~pop_q;
        rf_we   = pop_q;
      end
      ST_FUSED: begin
        mem_req  = 1'b1;
        rf_we    = mem_ack;
        rf_wdata = mem_rdata;
      end
      ST_FIN: begin
        done     = 1'b1;
        rf_we    = moved_q;
        rf_waddr = sp_sel_q;
        rf_wdata = sp_q;
      end
      default: ;
    endcase
  end

  // Next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (fire) begin
        if (!dec_ok)        state_d = ST_FIN;
        else if (dec_multi) state_d = ST_PREP;
        else if (dec_pop)   state_d = ST_FUSED;
        else                state_d = ST_GET;
      end
      ST_PREP:  state_d = pick_found ? ST_GET : ST_FIN;
      ST_GET:   if (!pop_q || mem_ack) state_d = ST_PUT;
      ST_PUT:   if (pop_q || mem_ack)
                  state_d = (mask_left == '0) ? ST_FIN : ST_GET;
      ST_FUSED: if (mem_ack) state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pop_q    <= 1'b0;
      moved_q  <= 1'b0;
      sp_sel_q <= '0;
      mask_q   <= '0;
      sp_q     <= '0;
      hold_q   <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: if (fire) begin
          pop_q    <= dec_pop;
          moved_q  <= 1'b0;
          sp_sel_q <= dec_sp;
          mask_q   <= dec_ok ? dec_mask : '0;
          sp_q     <= rf_rdata;
        end
        ST_GET: begin
          if (!pop_q) begin
            hold_q <= rf_rdata;
          end else if (mem_ack) begin
            hold_q  <= mem_rdata;
            sp_q    <= next_sp;
            moved_q <= 1'b1;
          end
        end
        ST_PUT: begin
          if (pop_q) begin
            mask_q <= mask_left;
          end else if (mem_ack) begin
            mask_q  <= mask_left;
            sp_q    <= next_sp;
            moved_q <= 1'b1;
          end
        end
        ST_FUSED: if (mem_ack) begin
          sp_q    <= next_sp;
          moved_q <= 1'b1;
          mask_q  <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pp_seq_chk.sv
module pp_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic              rf_we,
  input logic              mem_req,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              done
);
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_ready |=> !instr_ready);

  a_r1_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> instr_ready);

  a_r5_done_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  a_r3_no_reg_write_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !rf_we);

  a_r1_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ready |-> !mem_req && !rf_we);
endmodule

bind pp_seq pp_seq_chk #(.DATA_W(DATA_W)) u_pp_seq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_ready (instr_ready),
  .rf_we       (rf_we),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_ack     (mem_ack),
  .done        (done)
);

// File: tb/test_pp_seq.sv
module test_pp_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr = '0;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done;

  logic [31:0] regs [16];
  logic [31:0] mem  [64];
  int          wait_cfg = 0;
  int          wcnt = 0;
  int          n_req = 0;
  int          n_rfw = 0;
  int          n_checks = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  pp_seq i_pp_seq (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr(instr), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done)
  );

  assign rf_rdata  = regs[rf_raddr];
  assign mem_ack   = mem_req && (wcnt == wait_cfg);
  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (rf_we) regs[rf_waddr] <= rf_wdata;
    if (mem_req && mem_ack && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    if (mem_req && !mem_ack) wcnt <= wcnt + 1; else wcnt <= 0;
    if (mem_req) n_req <= n_req + 1;
    if (rf_we) n_rfw <= n_rfw + 1;
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [31:0] a);
    return mem[a[7:2]];
  endfunction

  // Issue one instruction, return cycles from accept to done inclusive
  task automatic run(input logic [31:0] w, output int cyc);
    @(negedge clk);
    n_req = 0; n_rfw = 0;
    instr = w; instr_valid = 1'b1;
    cyc = 1;
    @(negedge clk);
    instr_valid = 1'b0;
    cyc = 2;
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(instr_ready === 1'b1, "R11 ready", 32'(instr_ready), 1);
    check(mem_req === 1'b0 && rf_we === 1'b0 && done === 1'b0, "R11 quiet",
          {29'b0, mem_req, rf_we, done}, 0);
  endtask

  task automatic t_multi_push_pop;
    int c;
    regs[15] = 32'h100; regs[1] = 32'hA1; regs[3] = 32'hA3; regs[5] = 32'hA5;
    run({8'h62, 4'h0, 4'hF, 16'h002A}, c);
    check(c == 9, "R6 multi push cycles", c, 9);
    check(word(32'hFC) == 32'hA1 && word(32'hF8) == 32'hA3 && word(32'hF4) == 32'hA5,
          "R3 push order", word(32'hF4), 32'hA5);
    check(regs[15] == 32'hF4, "R5 sp after push", regs[15], 32'hF4);
    regs[1] = 0; regs[3] = 0; regs[5] = 0;
    run({8'h63, 4'h0, 4'hF, 16'h002A}, c);
    check(c == 9, "R6 multi pop cycles", c, 9);
    check(regs[1] == 32'hA1 && regs[3] == 32'hA3 && regs[5] == 32'hA5, "R4 restore",
          regs[5], 32'hA5);
    check(regs[15] == 32'h100, "R5 sp after pop", regs[15], 32'h100);
  endtask

  task automatic t_single;
    int c;
    regs[14] = 32'h80; regs[7] = 32'hC0FFEE07; regs[2] = 0;
    run({8'h60, 4'h7, 4'hE, 16'h0}, c);
    check(c == 4, "R6 single push cycles", c, 4);
    check(word(32'h7C) == 32'hC0FFEE07, "R2 single push data", word(32'h7C), 32'hC0FFEE07);
    check(regs[14] == 32'h7C, "R5 single push sp", regs[14], 32'h7C);
    run({8'h61, 4'h2, 4'hE, 16'h0}, c);
    check(c == 3, "R6 single pop cycles", c, 3);
    check(regs[2] == 32'hC0FFEE07, "R2 single pop data", regs[2], 32'hC0FFEE07);
    check(regs[14] == 32'h80, "R5 single pop sp", regs[14], 32'h80);
  endtask

  task automatic t_empty;
    int c;
    regs[15] = 32'h100;
    run({8'h62, 4'h0, 4'hF, 16'h0}, c);
    check(c == 3, "R7 empty cycles", c, 3);
    check(n_req == 0 && n_rfw == 0, "R7 no activity", 32'(n_req + n_rfw), 0);
    check(regs[15] == 32'h100, "R7 sp kept", regs[15], 32'h100);
  endtask

  task automatic t_sp_in_mask;
    int c;
    regs[15] = 32'h100; regs[0] = 32'h5A5A0000;
    run({8'h62, 4'h0, 4'hF, 16'h8001}, c);
    check(word(32'hFC) == 32'h5A5A0000, "R8 push r0 first", word(32'hFC), 32'h5A5A0000);
    check(word(32'hF8) == 32'h100, "R8 push old sp", word(32'hF8), 32'h100);
    mem[32'hF8 >> 2] = 32'hDEAD0000; regs[0] = 0;
    run({8'h63, 4'h0, 4'hF, 16'h8001}, c);
    check(regs[15] == 32'h100, "R8 pop sp wins", regs[15], 32'h100);
    check(regs[0] == 32'h5A5A0000, "R4 pop r0", regs[0], 32'h5A5A0000);
  endtask

  task automatic t_wait;
    int c;
    wait_cfg = 2;
    regs[13] = 32'hC0; regs[2] = 32'h22; regs[4] = 32'h44;
    run({8'h62, 4'h0, 4'hD, 16'h0014}, c);
    check(c == 11, "R9 wait cycles", c, 11);
    check(word(32'hBC) == 32'h22 && word(32'hB8) == 32'h44, "R9 data", word(32'hB8), 32'h44);
    wait_cfg = 0;
  endtask

  task automatic t_bad_op;
    int c;
    regs[15] = 32'h100;
    run({8'h55, 4'h1, 4'hF, 16'hFFFF}, c);
    check(c == 2, "R10 cycles", c, 2);
    check(n_req == 0 && n_rfw == 0, "R10 no activity", 32'(n_req + n_rfw), 0);
  endtask

  task automatic t_full;
    int c;
    for (int i = 0; i < 15; i++) regs[i] = 32'h1000 + 32'(i);
    regs[15] = 32'h100;
    run({8'h62, 4'h0, 4'hF, 16'hFFFF}, c);
    check(c == 35, "R6 full mask cycles", c, 35);
    check(regs[15] == 32'hC0, "R5 full sp", regs[15], 32'hC0);
    check(word(32'hC4) == 32'h100E && word(32'hC0) == 32'h100, "R3 full order",
          word(32'hC4), 32'h100E);
    for (int i = 0; i < 15; i++) regs[i] = 0;
    run({8'h63, 4'h0, 4'hF, 16'hFFFF}, c);
    check(regs[9] == 32'h1009 && regs[15] == 32'h100, "R4 full restore", regs[9], 32'h1009);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_multi_push_pop();
    t_single();
    t_empty();
    t_sp_in_mask();
    t_wait();
    t_bad_op();
    t_full();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule